// File: doc/BRIEF.md
# Looping Pseudo-Random Memory Self-Test

This block is a built-in self-test engine for a memory that sits behind a simple synchronous request port. A one-cycle start command launches it. Each pass fills an address range with words from a 32-bit pseudo-random generator, then reads the range back in the same order. It compares every returned word with the same sequence, regenerated a second time, and never keeps a copy of the written data. Reads are pipelined. The expected words wait in a small in-order queue until the matching read-valid returns. That queue also limits how many reads can be outstanding.

Once started, the engine never stops on its own. Each pass picks up the generator sequence where the previous pass left off, so every pass writes different values to every address. Status changes only at the boundary between passes: a done flag shows that at least one full pass has finished, and a fail flag latches any mismatch from any pass. Both flags clear only on reset or on a new start. The memory controller is expected to be reset before the test begins, so no reads are in flight when a start arrives.

Top module: `mbist_loop`

## Requirements
- R1: After synchronous reset, `done`, `fail` and `mem_req` are 0. No memory request is made until `start` is seen high.
- R2: A pass first writes every address from 0 up to WORDS-1 in ascending order, one write per cycle (`mem_req`=1, `mem_we`=1).
- R3: The word written to address a is the a-th state of a 32-bit Galois LFSR that starts at the pass seed. One step is: shift right by one, then XOR with 0x80200003 if the bit shifted out was 1. The first pass after `start` uses the seed parameter SEED.
- R4: The seed of each following pass is the LFSR state one step after the last word written, so consecutive passes write different words to the same address.
- R5: After the writes, the pass reads addresses 0 to WORDS-1 in ascending order (`mem_req`=1, `mem_we`=0). Each `mem_rvalid` return is compared, in order, with the regenerated word. No more than FIFO_DEPTH reads are ever outstanding.
- R6: `done` goes to 1 when the first pass finishes and then stays at 1.
- R7: `fail` changes only at the end of a pass. At that point it becomes 1 if any read of that pass mismatched. A mismatch does not show on `fail` while its pass is still running.
- R8: Once `fail` is 1, it stays 1 through later clean passes, until reset or `start`.
- R9: A `start` while the test is running clears `done` and `fail` and begins a new pass at address 0 with seed SEED.
- R10: Passes repeat without end until reset or `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command that starts or restarts the test |
| mem_req | output | 1 | Memory request valid (one request per high cycle) |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data returned by the memory |
| mem_rvalid | input | 1 | Read data valid; returns come in request order |
| done | output | 1 | At least one pass has completed |
| fail | output | 1 | Sticky: a mismatch was found in some finished pass |

## Verification
The bench models the memory with a read latency that varies between two and five cycles. This keeps the expected-word queue full, so a design that ignored the full condition would issue too many reads, and the model would catch the overflow. The model corrupts one read in the third pass only. A design that raised `fail` as soon as the bad word arrived would be caught by the check made before that pass ends. A design that dropped the flag in the clean pass that follows would also be caught. Every write is compared against an independent LFSR model that runs across passes. This exposes a seed that does not advance or advances wrongly, an address order that is off by one, and a restart that resumes the old sequence instead of SEED.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] TAP_MASK = 32'h8020_0003;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ, ST_DRAIN} mbist_state_e;

  function automatic logic [WORD_W-1:0] lfsr_next(input logic [WORD_W-1:0] s);
    lfsr_next = s[0] ? ((s >> 1) ^ TAP_MASK) : (s >> 1);
  endfunction
endpackage

// File: rtl/mbist_patgen.sv
module mbist_patgen
  import mbist_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] seed,
  input  logic              adv,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || load) word <= seed;
    else if (adv)    word <= lfsr_next(word);
  end
endmodule

// File: rtl/mbist_fifo.sv
module mbist_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     ram [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) ram[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = ram[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    full |-> !push)
    else $error("expected-word queue overflow");

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop)
    else $error("expected-word queue underflow");
endmodule

// File: rtl/mbist_loop.sv
module mbist_loop
  import mbist_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          WORDS      = 16,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [31:0] SEED       = 32'h1234_5678
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rvalid,
  output logic              done,
  output logic              fail
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

  mbist_state_e      state;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       pass_seed;
  logic              pass_err;
  logic [31:0]       wr_word, rd_word, exp_word;
  logic              fifo_empty, fifo_full;
  logic              wr_issue, rd_issue, rd_load, pop, mismatch, pass_end;

  assign wr_issue = !start && (state == ST_WRITE);
  assign rd_load  = wr_issue && (addr == LAST);
  assign rd_issue = !start && (state == ST_READ) && !fifo_full;
  assign pop      = mem_rvalid && !fifo_empty;
  assign mismatch = pop && (mem_rdata != exp_word);
  assign pass_end = (state == ST_DRAIN) && fifo_empty;

  // write-stream generator: runs on across passes
  mbist_patgen u_wgen (
    .clk(clk), .rst(rst), .load(start), .seed(SEED),
    .adv(wr_issue), .word(wr_word)
  );

  // read-stream generator: reloaded from the saved pass seed
  mbist_patgen u_rgen (
    .clk(clk), .rst(rst), .load(rd_load), .seed(pass_seed),
    .adv(rd_issue), .word(rd_word)
  );

  mbist_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_expq (
    .clk(clk), .rst(rst), .flush(start), .push(rd_issue), .din(rd_word),
    .pop(pop), .dout(exp_word), .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      pass_err  <= 1'b0;
      pass_seed <= SEED;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      if (mismatch) pass_err <= 1'b1;
      if (start) begin
        state     <= ST_WRITE;
        addr      <= '0;
        done      <= 1'b0;
        fail      <= 1'b0;
        pass_err  <= 1'b0;
        pass_seed <= SEED;
      end else begin
        case (state)
          ST_WRITE: begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= addr;
            mem_wdata <= wr_word;
            if (addr == LAST) begin
              addr  <= '0;
              state <= ST_READ;
            end else begin
              addr <= addr + 1'b1;
            end
          end
          ST_READ: begin
            if (!fifo_full) begin
              mem_req  <= 1'b1;
              mem_addr <= addr;
              if (addr == LAST) begin
                addr  <= '0;
                state <= ST_DRAIN;
              end else begin
                addr <= addr + 1'b1;
              end
            end
          end
          ST_DRAIN: begin
            if (fifo_empty) begin
              done      <= 1'b1;
              fail      <= fail | pass_err;
              pass_err  <= 1'b0;
              pass_seed <= wr_word;
              state     <= ST_WRITE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && !start |=> !mem_req)
    else $error("request while idle");

  assert_done_held_R6: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done)
    else $error("done dropped without start");

  assert_fail_at_pass_end_R7: assert property (@(posedge clk) disable iff (rst)
    !pass_end && !start |=> $stable(fail))
    else $error("fail changed inside a pass");

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fail && !start |=> fail)
    else $error("fail cleared without start");
endmodule

// File: tb/mbist_loop_bench.sv
`timescale 1ns/1ps
module mbist_loop_bench;
  localparam int          ADDR_W     = 8;
  localparam int          WORDS      = 16;
  localparam int          FIFO_DEPTH = 4;
  localparam logic [31:0] SEED       = 32'h1234_5678;
  localparam int          BAD_ADDR   = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              mem_req, mem_we, done, fail;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata = '0;
  logic              mem_rvalid = 1'b0;

  always #2 clk = ~clk;

  mbist_loop #(.ADDR_W(ADDR_W), .WORDS(WORDS), .FIFO_DEPTH(FIFO_DEPTH), .SEED(SEED))
  u_mbist_loop (
    .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .done(done), .fail(fail)
  );

  int errors = 0, checks = 0;
  int wr_cnt = 0, rd_cnt = 0, cyc = 0, last_due = 0, lat_ctr = 0;
  logic inj = 1'b0;
  logic [31:0] bseed;
  logic [31:0] w0 [8];
  logic [31:0] last_w0 = '0;
  int wq_addr[$];
  logic [31:0] wq_data[$];
  logic [31:0] pend_d[$];
  int pend_due[$];
  logic [31:0] mem [WORDS];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_step(input logic [31:0] s);
    logic [31:0] n;
    n = {1'b0, s[31:1]};
    if (s[0]) n = n ^ 32'h8020_0003;
    return n;
  endfunction

  // driver: pushes the expected writes of one pass into the scoreboard
  task automatic push_pass();
    for (int a = 0; a < WORDS; a++) begin
      wq_addr.push_back(a);
      wq_data.push_back(bseed);
      bseed = model_step(bseed);
    end
  endtask

  // memory model: variable in-order read latency, optional corruption
  always @(posedge clk) begin
    int lat, due;
    logic [31:0] d;
    cyc++;
    if (pend_d.size() > 0 && pend_due[0] <= cyc) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= pend_d.pop_front();
      void'(pend_due.pop_front());
    end else begin
      mem_rvalid <= 1'b0;
    end
    if (mem_req && mem_we) mem[int'(mem_addr) % WORDS] <= mem_wdata;
    if (mem_req && !mem_we) begin
      lat = 2 + (lat_ctr % 4);
      lat_ctr++;
      due = cyc + lat;
      if (due <= last_due) due = last_due + 1;
      last_due = due;
      d = mem[int'(mem_addr) % WORDS];
      if (inj && int'(mem_addr) == BAD_ADDR) d = d ^ 32'h0000_0100;
      pend_d.push_back(d);
      pend_due.push_back(due);
    end
  end

  // monitor: compares observed requests with the scoreboard
  always @(negedge clk) begin
    if (!rst && mem_req && mem_we) begin
      if (wq_data.size() == 0) begin
        chk(1'b0, "R10 unexpected write (scoreboard empty)", 32'(mem_addr), 0);
      end else begin
        int ea;
        logic [31:0] ed;
        ea = wq_addr.pop_front();
        ed = wq_data.pop_front();
        chk(int'(mem_addr) == ea, "R2 write address order", 32'(mem_addr), 32'(ea));
        chk(mem_wdata == ed, "R3/R4 write data", mem_wdata, ed);
      end
      if (mem_addr == '0) begin
        last_w0 = mem_wdata;
        if (wr_cnt / WORDS < 8) w0[wr_cnt / WORDS] = mem_wdata;
      end
      wr_cnt++;
    end
    if (!rst && mem_req && !mem_we) begin
      chk(int'(mem_addr) == rd_cnt % WORDS, "R5 read address order", 32'(mem_addr), 32'(rd_cnt % WORDS));
      chk(pend_d.size() <= FIFO_DEPTH, "R5 outstanding reads", 32'(pend_d.size()), 32'(FIFO_DEPTH));
      rd_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    bseed = SEED;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state and no activity before start
    chk(done == 1'b0, "R1 done after reset", 32'(done), 0);
    chk(fail == 1'b0, "R1 fail after reset", 32'(fail), 0);
    chk(mem_req == 1'b0 && wr_cnt == 0 && rd_cnt == 0, "R1 no request before start", 32'(wr_cnt + rd_cnt), 0);

    push_pass();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    for (int p = 0; p < 5; p++) begin
      wait (wr_cnt == (p + 1) * WORDS);
      if (p == 0) chk(done == 1'b0, "R6 done low during first pass", 32'(done), 0);
      push_pass();
      if (p == 2) begin
        inj = 1'b1;
        wait (rd_cnt == (p + 1) * WORDS);
        chk(fail == 1'b0, "R7 fail not raised before pass end", 32'(fail), 0);
      end
      wait (wr_cnt == (p + 1) * WORDS + 1);
      inj = 1'b0;
      chk(done == 1'b1, "R6 done after pass", 32'(done), 1);
      if (p < 2) chk(fail == 1'b0, "R7 fail clear after clean pass", 32'(fail), 0);
      else if (p == 2) chk(fail == 1'b1, "R7 fail set at end of corrupted pass", 32'(fail), 1);
      else chk(fail == 1'b1, "R8 fail held through clean pass", 32'(fail), 1);
      if (p == 1) chk(w0[1] != w0[0], "R4 pass words differ", w0[1], w0[0]);
    end
    chk(wr_cnt == 5 * WORDS + 1, "R10 test keeps looping", 32'(wr_cnt), 32'(5 * WORDS + 1));

    // R9: restart during the write phase
    wait (wr_cnt == 5 * WORDS + 3);
    wq_addr.delete();
    wq_data.delete();
    bseed = SEED;
    push_pass();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fail == 1'b0, "R8/R9 fail cleared by start", 32'(fail), 0);
    chk(done == 1'b0, "R9 done cleared by start", 32'(done), 0);
    base = wr_cnt;
    wait (wr_cnt == base + 1);
    chk(last_w0 == SEED, "R9 restart writes seed at address 0", last_w0, SEED);
    wait (wr_cnt == base + WORDS);
    push_pass();
    wait (wr_cnt == base + WORDS + 1);
    chk(done == 1'b1, "R9 done after restarted pass", 32'(done), 1);
    chk(fail == 1'b0, "R9 fail clean after restarted pass", 32'(fail), 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule